// File: doc/BRIEF.md
# Configurable asynchronous serial transceiver

A full-duplex transmitter and receiver for a two-wire asynchronous serial line. The frame format is chosen at run time: one to eight data bits, an optional parity bit of odd or even sense, and one or two stop bits. A 16-bit divisor, supplied as a high byte and a low byte, sets an oversample tick. Each bit on the line lasts eight of these ticks.

The host writes characters into a single transmit holding register and polls a ready flag. It reads received characters from a receive buffer, together with a ready flag and parity and framing error flags. The receiver is woken by a falling edge and samples each bit near its middle. It drops a start bit that has gone high again by its midpoint. An internal loopback path feeds the transmitter straight into the receiver, so the block can test itself without the pins. Separate enables gate each direction. A synchronous software reset returns both state machines and all status to their idle values.

Top module: `uart_xcvr`

## Requirements
- R1: With divisor D = {div_hi, div_lo}, one oversample tick occurs every D+1 clocks, and every bit on txd lasts exactly 8*(D+1) clocks (D = 0x01E7 gives 3904 clocks).
- R2: txd idles high. A frame is one low start bit, then cfg_char_len+1 data bits least significant bit first (code 7 is 8 bits, code 0 is 1 bit), then the optional parity bit, then the stop bits, which are high.
- R3: When cfg_par_en is 1, a parity bit follows the data. cfg_par_even = 0 makes the total count of ones in data plus parity odd, and 1 makes it even.
- R4: cfg_two_stop = 0 sends one stop bit and 1 sends two. When a character is waiting, the next start bit begins right after the last stop bit, so start edges are exactly one frame length apart.
- R5: tx_ready is high while the holding register is empty. A tx_wr pulse while it is high stores tx_data and drops it. A tx_wr pulse while it is low is ignored. It rises again when the character moves into the shifter.
- R6: A received frame sets rx_ready and places the data in the low cfg_char_len+1 bits of rx_data, with the unused high bits at zero.
- R7: A one-clock rx_rd pulse clears rx_ready on the next clock and leaves rx_data unchanged.
- R8: Each received character updates the error flags. rx_par_err is set on a parity mismatch when parity is enabled. rx_frm_err is set when the first stop bit samples low.
- R9: A low pulse on the line shorter than half a bit is not taken as a start bit, and the receiver stays ready for the next frame.
- R10: With cfg_loopback = 1 the receiver hears the transmitter internally, the txd pin stays high and rxd is ignored.
- R11: With tx_en = 0 a stored character stays in the holding register and txd stays high. With rx_en = 0 incoming frames are not received.
- R12: A one-clock soft_rst sets tx_ready to 1, clears rx_ready, rx_par_err and rx_frm_err, discards a waiting character and returns txd high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous software reset of state and status |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| cfg_char_len | input | 3 | Data bit count minus one |
| cfg_par_en | input | 1 | Add and check a parity bit |
| cfg_par_even | input | 1 | Parity sense: 0 odd, 1 even |
| cfg_two_stop | input | 1 | Stop bits: 0 one, 1 two |
| cfg_loopback | input | 1 | Route the transmitter to the receiver internally |
| div_hi | input | 8 | Divisor high byte |
| div_lo | input | 8 | Divisor low byte |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Holding register empty |
| rx_rd | input | 1 | Read strobe, clears rx_ready |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | Unread character present |
| rx_par_err | output | 1 | Parity error on the last character |
| rx_frm_err | output | 1 | Framing error on the last character |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |

## Verification
The bench builds the block with its default parameters: 8 data bits at most, a 16-bit divisor and 8 ticks per bit. At run time it sets the divisor to 0, to 3 and to 0x01E7. Divisor 0 gives a tick on every clock, which exercises the shortest bit. Divisor 3 gives a 32-clock bit, with room to place glitches and bad stop or parity bits at known points. Divisor 0x01E7 carries a nonzero high byte through the full-width counter and confirms the 3904-clock bit.

// File: rtl/uart_xcvr.sv
module uart_xcvr #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int OVS    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      soft_rst,
  input  logic                      tx_en,
  input  logic                      rx_en,
  input  logic [$clog2(DATA_W)-1:0] cfg_char_len,
  input  logic                      cfg_par_en,
  input  logic                      cfg_par_even,
  input  logic                      cfg_two_stop,
  input  logic                      cfg_loopback,
  input  logic [DIV_W/2-1:0]        div_hi,
  input  logic [DIV_W/2-1:0]        div_lo,
  input  logic                      tx_wr,
  input  logic [DATA_W-1:0]         tx_data,
  output logic                      tx_ready,
  input  logic                      rx_rd,
  output logic [DATA_W-1:0]         rx_data,
  output logic                      rx_ready,
  output logic                      rx_par_err,
  output logic                      rx_frm_err,
  input  logic                      rxd,
  output logic                      txd
);
  localparam int SUB_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OVS / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  // oversample tick
  logic [DIV_W-1:0] div_val, bcnt;
  logic             tick;
  assign div_val = {div_hi, div_lo};
  assign tick    = !soft_rst && (bcnt >= div_val);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            bcnt <= '0;
    else if (soft_rst || bcnt >= div_val)  bcnt <= '0;
    else                                   bcnt <= bcnt + 1'b1;

  logic [DATA_W-1:0] len_mask;
  assign len_mask = {DATA_W{1'b1}} >> (IDX_W'(DATA_W - 1) - cfg_char_len);

  // transmitter
  st_t               tx_st;
  logic [SUB_W-1:0]  tx_sub;
  logic [IDX_W-1:0]  tx_idx;
  logic [DATA_W-1:0] tx_hold, tx_sh, tx_word;
  logic              tx_full, tx_out, tx_par, tx_bit_end, tx_done, tx_load;

  assign tx_word    = tx_hold & len_mask;
  assign tx_bit_end = tick && tx_sub == SUB_LAST;
  assign tx_done    = tx_st == S_STOP && tx_bit_end && !(cfg_two_stop && tx_idx == '0);
  assign tx_load    = tick && tx_full && tx_en && (tx_st == S_IDLE || tx_done);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_st <= S_IDLE; tx_sub <= '0; tx_idx <= '0; tx_hold <= '0;
      tx_sh <= '0; tx_full <= 1'b0; tx_out <= 1'b1; tx_par <= 1'b0;
    end else if (soft_rst) begin
      tx_st <= S_IDLE; tx_sub <= '0; tx_idx <= '0;
      tx_full <= 1'b0; tx_out <= 1'b1;
    end else begin
      if (tx_load)
        tx_full <= 1'b0;
      else if (tx_wr && !tx_full) begin
        tx_hold <= tx_data;
        tx_full <= 1'b1;
      end
      if (tx_load) begin
        tx_st  <= S_START;
        tx_sub <= '0;
        tx_idx <= '0;
        tx_sh  <= tx_word;
        tx_par <= cfg_par_even ? ^tx_word : ~^tx_word;
        tx_out <= 1'b0;
      end else if (tx_done) begin
        tx_st  <= S_IDLE;
        tx_out <= 1'b1;
      end else if (tick && tx_st != S_IDLE) begin
        tx_sub <= tx_sub + 1'b1;
        if (tx_sub == SUB_LAST)
          case (tx_st)
            S_START: begin
              tx_st  <= S_DATA;
              tx_out <= tx_sh[0];
            end
            S_DATA:
              if (tx_idx == cfg_char_len) begin
                tx_idx <= '0;
                tx_st  <= cfg_par_en ? S_PAR : S_STOP;
                tx_out <= cfg_par_en ? tx_par : 1'b1;
              end else begin
                tx_idx <= tx_idx + 1'b1;
                tx_out <= tx_sh[1];
                tx_sh  <= tx_sh >> 1;
              end
            S_PAR: begin
              tx_st  <= S_STOP;
              tx_out <= 1'b1;
            end
            S_STOP:  tx_idx <= IDX_W'(1);
            default: tx_st <= S_IDLE;
          endcase
      end
    end

  assign tx_ready = !tx_full;
  assign txd      = cfg_loopback ? 1'b1 : tx_out;

  // receiver
  st_t               rx_st;
  logic [1:0]        rx_sync;
  logic              line, rx_pbit, rx_rdy, perr, ferr, rx_bit_end;
  logic [SUB_W-1:0]  rx_sub;
  logic [IDX_W-1:0]  rx_idx;
  logic [DATA_W-1:0] rx_sh, rx_buf;

  assign line       = rx_sync[1];
  assign rx_bit_end = tick && rx_sub == SUB_LAST;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else        rx_sync <= {rx_sync[0], cfg_loopback ? tx_out : rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_st <= S_IDLE; rx_sub <= '0; rx_idx <= '0; rx_sh <= '0; rx_buf <= '0;
      rx_pbit <= 1'b0; rx_rdy <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
    end else if (soft_rst) begin
      rx_st <= S_IDLE; rx_sub <= '0; rx_idx <= '0;
      rx_rdy <= 1'b0; perr <= 1'b0; ferr <= 1'b0;
    end else begin
      if (rx_rd) rx_rdy <= 1'b0;
      if (tick)
        case (rx_st)
          S_IDLE:
            if (rx_en && !line) begin
              rx_st  <= S_START;
              rx_sub <= '0;
            end
          S_START:
            if (rx_sub == SUB_MID) begin
              rx_sub <= '0;
              rx_idx <= '0;
              rx_sh  <= '0;
              rx_st  <= line ? S_IDLE : S_DATA;
            end else rx_sub <= rx_sub + 1'b1;
          S_DATA: begin
            rx_sub <= rx_sub + 1'b1;
            if (rx_bit_end) begin
              rx_sh[rx_idx] <= line;
              if (rx_idx == cfg_char_len) rx_st <= cfg_par_en ? S_PAR : S_STOP;
              else                        rx_idx <= rx_idx + 1'b1;
            end
          end
          S_PAR: begin
            rx_sub <= rx_sub + 1'b1;
            if (rx_bit_end) begin
              rx_pbit <= line;
              rx_st   <= S_STOP;
            end
          end
          S_STOP: begin
            rx_sub <= rx_sub + 1'b1;
            if (rx_bit_end) begin
              rx_st  <= S_IDLE;
              rx_buf <= rx_sh;
              rx_rdy <= 1'b1;
              ferr   <= !line;
              perr   <= cfg_par_en && (cfg_par_even ? (^rx_sh ^ rx_pbit) : !(^rx_sh ^ rx_pbit));
            end
          end
          default: rx_st <= S_IDLE;
        endcase
    end

  assign rx_data    = rx_buf;
  assign rx_ready   = rx_rdy;
  assign rx_par_err = perr;
  assign rx_frm_err = ferr;

  // R1: ticks are spaced by the divisor
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_val != '0) |=> (!tick || div_val == '0));
  // R2: a loaded character opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !soft_rst) |=> (tx_st == S_START && !tx_out));
  // R2: an idle transmitter holds the line high
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st == S_IDLE) |-> tx_out);
  // R5: the holding register frees up when the shifter takes it
  a_r5_ready_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_ready);
  // R7: a read without a simultaneous completion clears the ready flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !(rx_st == S_STOP && rx_bit_end)) |=> !rx_ready);
  // R11: a disabled receiver never leaves idle
  a_r11_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && rx_st == S_IDLE && !soft_rst) |=> rx_st == S_IDLE);
  // R12: software reset restores the status
  a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (tx_ready && !rx_ready && !rx_par_err && !rx_frm_err && txd));
endmodule

// File: tb/uart_xcvr_tb.sv
module uart_xcvr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, soft_rst = 1'b0, tx_en = 1'b1, rx_en = 1'b1;
  logic [2:0] cfg_char_len = 3'd7;
  logic cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_two_stop = 1'b0, cfg_loopback = 1'b0;
  logic [7:0] div_hi = 8'd0, div_lo = 8'd3;
  logic tx_wr = 1'b0, rx_rd = 1'b0, rxd = 1'b1;
  logic [7:0] tx_data = 8'd0;
  logic tx_ready, rx_ready, rx_par_err, rx_frm_err, txd;
  logic [7:0] rx_data;

  int nchk = 0, nerr = 0, txd_lows = 0;
  longint cyc = 0;
  bit done = 1'b0, watch_lows = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (watch_lows && txd !== 1'b1) txd_lows++;

  uart_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tx_en(tx_en), .rx_en(rx_en),
    .cfg_char_len(cfg_char_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_two_stop(cfg_two_stop), .cfg_loopback(cfg_loopback), .div_hi(div_hi), .div_lo(div_lo),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_ready(tx_ready), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rxd(rxd), .txd(txd)
  );

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_fmt(input int nbits, input bit pe, input bit ev, input bit ts);
    cfg_char_len = 3'(nbits - 1); cfg_par_en = pe; cfg_par_even = ev; cfg_two_stop = ts;
  endtask

  function automatic bit par_of(input logic [7:0] d, input int n, input bit ev);
    logic [7:0] m = d & 8'((1 << n) - 1);
    return ev ? ^m : ~^m;
  endfunction

  task automatic send(input logic [7:0] d);
    while (tx_ready !== 1'b1) @(negedge clk);
    tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  // per-clock comparison of txd against the expected frame
  task automatic watch_tx(input logic [7:0] d, input int n, input bit pe, input bit ev,
                          input bit ts, input int bp, input string req, output longint t0);
    bit q[$];
    int mism = 0;
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    q.push_back(1'b0);
    for (int i = 0; i < n; i++) q.push_back(d[i]);
    if (pe) q.push_back(par_of(d, n, ev));
    q.push_back(1'b1);
    if (ts) q.push_back(1'b1);
    for (int k = 0; k < q.size() * bp; k++) begin
      if (txd !== q[k / bp]) mism++;
      @(negedge clk);
    end
    chk(mism == 0, req, "tx frame clocks in error", mism, 0);
  endtask

  task automatic drive_rx(input logic [7:0] d, input int n, input bit pe, input bit ev, input bit ts,
                          input int bp, input bit bad_par, input bit bad_stop);
    rxd = 1'b0; wait_clk(bp);
    for (int i = 0; i < n; i++) begin rxd = d[i]; wait_clk(bp); end
    if (pe) begin rxd = par_of(d, n, ev) ^ bad_par; wait_clk(bp); end
    rxd = !bad_stop; wait_clk(bp);
    rxd = 1'b1;
    if (ts) wait_clk(bp);
  endtask

  task automatic do_read;
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual expired expected finished");
    finish_run();
  end

  initial begin
    longint t0, t1;
    logic [7:0] keep;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    chk(txd == 1'b1, "R2", "idle line after reset", txd, 1);
    chk(tx_ready == 1'b1, "R5", "tx_ready after reset", tx_ready, 1);
    chk(rx_ready == 1'b0 && rx_par_err == 1'b0 && rx_frm_err == 1'b0, "R12", "rx status after reset",
        {rx_ready, rx_par_err, rx_frm_err}, 0);

    // R2: 8 data bits, no parity, one stop, 32-clock bits
    fork send(8'hA5); watch_tx(8'hA5, 8, 0, 0, 0, 32, "R2", t0); join

    // R3 even + R4 two stops, back to back
    set_fmt(7, 1, 1, 1);
    fork
      begin send(8'h5C); send(8'h33); end
      begin watch_tx(8'h5C, 7, 1, 1, 1, 32, "R3", t0); watch_tx(8'h33, 7, 1, 1, 1, 32, "R3", t1); end
    join
    chk(t1 - t0 == 11 * 32, "R4", "two-stop start spacing", t1 - t0, 11 * 32);

    // R3 odd + R4 one stop
    set_fmt(5, 1, 0, 0);
    fork
      begin send(8'h1B); send(8'h04); end
      begin watch_tx(8'h1B, 5, 1, 0, 0, 32, "R3", t0); watch_tx(8'h04, 5, 1, 0, 0, 32, "R3", t1); end
    join
    chk(t1 - t0 == 8 * 32, "R4", "one-stop start spacing", t1 - t0, 8 * 32);

    // R1: divisor 0x01E7 with one data bit, then divisor 0
    wait_clk(40);
    set_fmt(1, 0, 0, 0); div_hi = 8'h01; div_lo = 8'hE7;
    fork send(8'h01); watch_tx(8'h01, 1, 0, 0, 0, 3904, "R1", t0); join
    set_fmt(8, 0, 0, 0); div_hi = 8'h00; div_lo = 8'h00;
    fork send(8'hC3); watch_tx(8'hC3, 8, 0, 0, 0, 8, "R1", t0); join
    wait_clk(20);
    div_lo = 8'd3;
    wait_clk(20);

    // R6/R7 receive and read
    drive_rx(8'h96, 8, 0, 0, 0, 32, 0, 0);
    chk(rx_ready == 1'b1, "R6", "rx_ready after frame", rx_ready, 1);
    chk(rx_data == 8'h96, "R6", "rx_data 8 bits", rx_data, 8'h96);
    do_read();
    chk(rx_ready == 1'b0, "R7", "rx_ready after read", rx_ready, 0);
    chk(rx_data == 8'h96, "R7", "rx_data held after read", rx_data, 8'h96);

    // R6 short character, upper bits zero
    set_fmt(5, 1, 1, 0);
    drive_rx(8'hFF, 5, 1, 1, 0, 32, 0, 0);
    chk(rx_data == 8'h1F, "R6", "5-bit rx_data", rx_data, 8'h1F);
    chk(rx_par_err == 1'b0, "R8", "good parity flag", rx_par_err, 0);
    do_read();

    // R8 parity error
    drive_rx(8'h0A, 5, 1, 1, 0, 32, 1, 0);
    chk(rx_ready && rx_par_err == 1'b1, "R8", "parity error flag", rx_par_err, 1);
    chk(rx_frm_err == 1'b0, "R8", "no framing error with bad parity", rx_frm_err, 0);
    do_read();

    // R8 framing error, then cleared by the next good character
    set_fmt(8, 0, 0, 0);
    drive_rx(8'h3C, 8, 0, 0, 0, 32, 0, 1);
    chk(rx_frm_err == 1'b1, "R8", "framing error flag", rx_frm_err, 1);
    chk(rx_data == 8'h3C, "R8", "data with framing error", rx_data, 8'h3C);
    wait_clk(40);
    do_read();
    drive_rx(8'h11, 8, 0, 0, 0, 32, 0, 0);
    chk(rx_frm_err == 1'b0 && rx_par_err == 1'b0, "R8", "flags per character", {rx_frm_err, rx_par_err}, 0);
    do_read();

    // R9 glitch rejection
    rxd = 1'b0; wait_clk(6); rxd = 1'b1; wait_clk(96);
    chk(rx_ready == 1'b0, "R9", "glitch not received", rx_ready, 0);
    drive_rx(8'h7E, 8, 0, 0, 0, 32, 0, 0);
    chk(rx_ready && rx_data == 8'h7E, "R9", "frame after glitch", rx_data, 8'h7E);
    do_read();

    // R10 loopback
    cfg_loopback = 1'b1; wait_clk(2); rxd = 1'b0;
    txd_lows = 0; watch_lows = 1'b1;
    send(8'h6D);
    wait_clk(12 * 32);
    watch_lows = 1'b0;
    chk(rx_ready && rx_data == 8'h6D, "R10", "loopback data", rx_data, 8'h6D);
    chk(txd_lows == 0, "R10", "txd pin low clocks in loopback", txd_lows, 0);
    do_read();
    rxd = 1'b1; wait_clk(4); cfg_loopback = 1'b0; wait_clk(4);

    // R11 tx disabled, R5 write ignored while full
    tx_en = 1'b0;
    txd_lows = 0; watch_lows = 1'b1;
    send(8'h42);
    wait_clk(300);
    chk(tx_ready == 1'b0, "R11", "character held while disabled", tx_ready, 0);
    tx_data = 8'h99; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
    watch_lows = 1'b0;
    chk(txd_lows == 0, "R11", "txd low clocks while disabled", txd_lows, 0);
    tx_en = 1'b1;
    watch_tx(8'h42, 8, 0, 0, 0, 32, "R5", t0);
    chk(tx_ready == 1'b1, "R5", "ready after ignored write", tx_ready, 1);
    wait_clk(40);

    // R11 rx disabled
    rx_en = 1'b0;
    drive_rx(8'h55, 8, 0, 0, 0, 32, 0, 0);
    wait_clk(32);
    chk(rx_ready == 1'b0, "R11", "frame ignored while rx disabled", rx_ready, 0);
    rx_en = 1'b1;

    // R12 software reset
    set_fmt(8, 1, 0, 0);
    drive_rx(8'h21, 8, 1, 0, 0, 32, 1, 0);
    keep = rx_data;
    chk(rx_ready && rx_par_err, "R12", "status set before reset", {rx_ready, rx_par_err}, 2'b11);
    tx_en = 1'b0; send(8'h77);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    chk(tx_ready == 1'b1 && txd == 1'b1, "R12", "tx side after reset", {tx_ready, txd}, 2'b11);
    chk(rx_ready == 1'b0 && rx_par_err == 1'b0 && rx_frm_err == 1'b0, "R12", "rx status after reset",
        {rx_ready, rx_par_err, rx_frm_err}, 0);
    txd_lows = 0; watch_lows = 1'b1;
    tx_en = 1'b1; wait_clk(200);
    watch_lows = 1'b0;
    chk(txd_lows == 0, "R12", "discarded character not sent", txd_lows, 0);
    if (keep != 8'h21) chk(1'b0, "R6", "data before reset", keep, 8'h21);

    finish_run();
  end
endmodule